// File: doc/BRIEF.md
# Interleaved Weighted Round-Robin Address Arbiter

This block decides which of several masters may drive the address channel of one shared slave. Each master has a fixed integer weight. A full round of service gives each master as many slots as its weight. The slots are spread out rather than taken in one block: the round is split into sub-rounds, as many as the largest weight. In sub-round k, only masters whose weight exceeds k take part. Within a sub-round, masters are visited from the lowest index upward. With weights 5, 3, 2 and 1 for masters 0 to 3, a fully loaded round grants in the order 0,1,2,3,0,1,2,0,1,0,0.

A request is a master's address valid aimed at this slave. A grant covers exactly one address handshake, whatever the burst length. The grant is combinational from the requests and the stored pointer, so a master that is waiting is served in the same cycle. Slots of masters that are not requesting are skipped without a lost cycle. Once a grant has been shown while the slave is stalling, the grant stays fixed until the handshake completes. The one-hot grant and the index let the data and response paths follow the same order. One instance serves writes and a separate instance serves reads.

Weights are given as one flattened vector. The most significant 32-bit field holds the weight of master 0.

Top module: `iwrr_arbiter`

## Requirements
- R1: After reset with no requests, grant is all zero and grant_valid is 0. The first grant of a fully loaded run goes to master 0.
- R2: grant is one-hot with bit grant_idx set whenever grant_valid is 1, and grant is zero when grant_valid is 0.
- R3: With weights 5,3,2,1 and all four masters requesting with ready held high, the grant order is 0,1,2,3,0,1,2,0,1,0,0, and this order repeats for the next round.
- R4: Slots of non-requesting masters are skipped in the same cycle. With only masters 1 and 3 requesting under weights 5,3,2,1, the order is 1,3,1,1 for each round.
- R5: When at least one master with non-zero weight requests, grant_valid is 1 in that same cycle. A lone requester is granted at once, wherever the pointer stands.
- R6: While grant_valid is 1 and ready is 0, the grant does not change, even when other masters raise requests.
- R7: The pointer moves only on a cycle with grant_valid and ready both 1. A stalled grant consumes a single slot however long it waits.
- R8: A master whose weight is 0 is never granted. With weights 0,2,1,0 and all masters requesting, the order is 1,2,1 for each round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N | Address valid from each master aimed at this slave; bit i is master i |
| ready | input | 1 | Address ready from the slave |
| grant | output | N | One-hot grant; bit i is master i |
| grant_idx | output | max(1,clog2(N)) | Index of the granted master |
| grant_valid | output | 1 | A grant is being presented |

## Verification
Grant, grant_idx and grant_valid follow the requests in the same cycle, with no register on the path. The effect of a handshake on the pointer, and the grant lock set by a stall, show up only after the next rising edge. The bench therefore changes req and ready on the falling edge and reads the outputs one nanosecond later. Each reading reflects the inputs of the current cycle and the state left by the previous rising edge. Each expected grant sequence is therefore a plain list of indices, one per clock.

// File: rtl/iwrr_arbiter.sv
module iwrr_arbiter #(
  parameter int N = 4,
  parameter logic [0:N*32-1] WEIGHTS = {32'd5, 32'd3, 32'd2, 32'd1}
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N-1:0]                   req,
  input  logic                           ready,
  output logic [N-1:0]                   grant,
  output logic [(N>1?$clog2(N):1)-1:0]   grant_idx,
  output logic                           grant_valid
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int PW = $clog2(N + 1);

  function automatic logic [31:0] wt(input int i);
    return WEIGHTS[i*32 +: 32];
  endfunction

  function automatic logic [N-1:0] nz_mask();
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (WEIGHTS[i*32 +: 32] != 32'd0);
    return m;
  endfunction

  localparam logic [N-1:0] LIVE = nz_mask();

  logic [31:0]   sub_q, hold_sub_q, cur_sub, pick_sub;
  logic [PW-1:0] pos_q;
  logic          hold_q;
  logic [IW-1:0] hold_idx_q, cur_idx, pick_idx;
  logic          a_ok, b_ok, c_ok, pick_ok;
  logic [IW-1:0] a_idx, b_idx, c_idx;

  always_comb begin
    a_ok = 1'b0; b_ok = 1'b0; c_ok = 1'b0;
    a_idx = '0;  b_idx = '0;  c_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i] && wt(i) > sub_q && PW'(i) >= pos_q) begin
        a_ok = 1'b1; a_idx = IW'(i);
      end
      if (req[i] && wt(i) > sub_q + 32'd1) begin
        b_ok = 1'b1; b_idx = IW'(i);
      end
      if (req[i] && wt(i) != 32'd0) begin
        c_ok = 1'b1; c_idx = IW'(i);
      end
    end
    pick_ok  = a_ok | b_ok | c_ok;
    pick_idx = a_ok ? a_idx : (b_ok ? b_idx : c_idx);
    pick_sub = a_ok ? sub_q : (b_ok ? sub_q + 32'd1 : 32'd0);
  end

  assign grant_valid = hold_q | pick_ok;
  assign cur_idx     = hold_q ? hold_idx_q : pick_idx;
  assign cur_sub     = hold_q ? hold_sub_q : pick_sub;
  assign grant_idx   = cur_idx;
  assign grant       = grant_valid ? (N'(1) << cur_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q      <= '0;
      pos_q      <= '0;
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
      hold_sub_q <= '0;
    end else if (grant_valid) begin
      if (ready) begin
        hold_q <= 1'b0;
        sub_q  <= cur_sub;
        pos_q  <= PW'(cur_idx) + PW'(1);
      end else begin
        hold_q     <= 1'b1;
        hold_idx_q <= cur_idx;
        hold_sub_q <= cur_sub;
      end
    end
  end

  assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ($onehot(grant) && grant[cur_idx]));

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> (grant == '0));

  assert_no_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    |(req & LIVE) |-> grant_valid);

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !ready) |=> (grant_valid && $stable(grant)));

  assert_to_requester_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !hold_q) |-> ((grant & req) != '0));

  for (genvar g = 0; g < N; g++) begin : g_zero
    if (WEIGHTS[g*32 +: 32] == 32'd0) begin : g_chk
      assert_zero_weight_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !grant[g]);
    end
  end

endmodule

// File: tb/test_iwrr_arbiter.sv
module test_iwrr_arbiter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] req;
  logic       ready;
  logic [3:0] grant, grant2;
  logic [1:0] grant_idx, grant_idx2;
  logic       grant_valid, grant_valid2;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  iwrr_arbiter #(.N(4), .WEIGHTS({32'd5, 32'd3, 32'd2, 32'd1})) i_iwrr_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .ready(ready),
    .grant(grant), .grant_idx(grant_idx), .grant_valid(grant_valid));

  iwrr_arbiter #(.N(4), .WEIGHTS({32'd0, 32'd2, 32'd1, 32'd0})) i_iwrr_arbiter_z (
    .clk(clk), .rst_n(rst_n), .req(req), .ready(ready),
    .grant(grant2), .grant_idx(grant_idx2), .grant_valid(grant_valid2));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic look(input string tag, input bit sel, input bit ev, input int ei);
    logic [3:0] g;
    logic       v;
    logic [1:0] x;
    g = sel ? grant2 : grant;
    v = sel ? grant_valid2 : grant_valid;
    x = sel ? grant_idx2 : grant_idx;
    chk({tag, " valid"}, int'(v), int'(ev));
    chk({"R2 vector (", tag, ")"}, int'(g), ev ? (1 << ei) : 0);
    if (ev) chk({tag, " index"}, int'(x), ei);
  endtask

  task automatic apply(input logic [3:0] r, input logic rd);
    @(negedge clk);
    req = r;
    ready = rd;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req = '0;
    ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_R1();
    do_reset();
    apply(4'b0000, 1'b1);
    look("R1 idle after reset", 0, 0, 0);
    apply(4'b1111, 1'b1);
    look("R1 first grant", 0, 1, 0);
  endtask

  task automatic t_full_round_R3();
    int seq[11] = '{0, 1, 2, 3, 0, 1, 2, 0, 1, 0, 0};
    do_reset();
    for (int n = 0; n < 22; n++) begin
      apply(4'b1111, 1'b1);
      look("R3 loaded order", 0, 1, seq[n % 11]);
    end
  endtask

  task automatic t_skip_R4();
    int seq[4] = '{1, 3, 1, 1};
    do_reset();
    for (int n = 0; n < 12; n++) begin
      apply(4'b1010, 1'b1);
      look("R4 skip idle", 0, 1, seq[n % 4]);
    end
  endtask

  task automatic t_lone_R5();
    do_reset();
    apply(4'b0000, 1'b1);
    look("R5 no request", 0, 0, 0);
    apply(4'b0100, 1'b1);
    look("R5 lone master 2", 0, 1, 2);
    apply(4'b0001, 1'b1);
    look("R5 lone master 0 past pointer", 0, 1, 0);
    apply(4'b0001, 1'b1);
    look("R5 lone master 0 again", 0, 1, 0);
  endtask

  task automatic t_hold_R6();
    do_reset();
    apply(4'b1000, 1'b0);
    look("R6 stalled grant", 0, 1, 3);
    apply(4'b1001, 1'b0);
    look("R6 held vs new request", 0, 1, 3);
    apply(4'b1001, 1'b0);
    look("R6 still held", 0, 1, 3);
    apply(4'b1001, 1'b1);
    look("R6 handshake", 0, 1, 3);
    apply(4'b0001, 1'b1);
    look("R6 next sub-round", 0, 1, 0);
    apply(4'b1111, 1'b1);
    look("R6 resume 1", 0, 1, 1);
    apply(4'b1111, 1'b1);
    look("R6 resume 2", 0, 1, 2);
    apply(4'b1111, 1'b1);
    look("R6 resume 0", 0, 1, 0);
  endtask

  task automatic t_advance_R7();
    int seq[5] = '{0, 1, 2, 3, 0};
    do_reset();
    for (int n = 0; n < 3; n++) begin
      apply(4'b1111, 1'b0);
      look("R7 no advance while stalled", 0, 1, 0);
    end
    for (int n = 0; n < 5; n++) begin
      apply(4'b1111, 1'b1);
      look("R7 one slot consumed", 0, 1, seq[n]);
    end
  endtask

  task automatic t_zero_R8();
    int seq[3] = '{1, 2, 1};
    do_reset();
    apply(4'b0001, 1'b1);
    look("R8 zero weight master 0", 1, 0, 0);
    apply(4'b1001, 1'b1);
    look("R8 zero weight masters 0,3", 1, 0, 0);
    for (int n = 0; n < 9; n++) begin
      apply(4'b1111, 1'b1);
      look("R8 order", 1, 1, seq[n % 3]);
    end
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req = '0;
    ready = 1'b1;
    t_reset_R1();
    t_full_round_R3();
    t_skip_R4();
    t_lone_R5();
    t_hold_R6();
    t_advance_R7();
    t_zero_R8();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule